// File: doc/BRIEF.md
# Branch Condition and Target Resolver

This unit settles the outcome of one jump-class instruction of a 64-bit register virtual machine. It receives the 8-bit opcode, the 16-bit signed displacement, the 32-bit immediate, the values of the two operand registers and the current program counter. The counter is counted in instruction slots. From these inputs it decides whether the branch is taken and works out the address of the next instruction. It also reports when the instruction asks for a subroutine call, asks for a program return, or is not a legal jump.

The opcode splits into three fields. The low three bits pick the instruction class. Bit 3 picks the comparison operand. The top four bits pick the condition. One class compares the full 64-bit values. The other compares only their low 32 bits. The unit does not run the call, does not carry out the return and does not fetch instructions. It only flags these events for the sequencer around it. All outputs are registered, so a result appears one clock after its inputs.

Top module: `branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero on that edge, including `next_pc_o`.
- R2: Class field `opcode_i[2:0]` = 5 compares 64-bit operands and = 6 compares only bits 31:0 of both operands. Any other class value raises `illegal_o`.
- R3: With `opcode_i[3]` = 0 the right-hand operand is `imm_i` sign-extended to 64 bits. With `opcode_i[3]` = 1 it is `src_val_i`. The left-hand operand is always `dst_val_i`.
- R4: Condition field `opcode_i[7:4]` = 1 is taken when the operands are equal, = 5 when they differ, and = 4 when their bitwise AND is nonzero.
- R5: Unsigned relations: field 2 is taken when left > right, 3 when left >= right, 10 when left < right and 11 when left <= right.
- R6: Signed (two's complement) relations use the same order as R5: field 6 is >, 7 is >=, 12 is < and 13 is <=.
- R7: When taken, `next_pc_o` = pc + 1 + sign-extended offset, modulo 2^PC_W. In every other case it is pc + 1, modulo 2^PC_W.
- R8: Field 0 is an unconditional taken jump in class 5 and illegal in class 6.
- R9: Field 8 raises `call_o` in either class. Field 9 raises `exit_o` in class 5 only and is illegal in class 6. Neither one takes the branch.
- R10: Fields 14 and 15 are illegal. Whenever `illegal_o` is high, `taken_o`, `call_o` and `exit_o` are low. At most one of the four flags is high at a time.
- R11: The outputs update only on a rising clock edge, one cycle after the inputs they reflect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 8 | Instruction opcode (class, operand select, condition) |
| offset_i | input | 16 | Signed branch displacement in instructions |
| imm_i | input | 32 | Immediate operand |
| dst_val_i | input | 64 | Left-hand register value |
| src_val_i | input | 64 | Right-hand register value |
| pc_i | input | PC_W (32) | Current program counter |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | PC_W (32) | Address of next instruction |
| call_o | output | 1 | Subroutine call requested |
| exit_o | output | 1 | Program return requested |
| illegal_o | output | 1 | Opcode is not a legal jump |

## Verification
The bench applies all 256 opcode values to a set of operand vectors. Each vector is built so that some condition's answer depends on one thing only: the operand width, the signedness, or immediate sign extension. For example, one vector has equal low halves but different high halves, so a design that ignored the class bit would take the 32-bit and 64-bit forms of a branch the same way. Other vectors catch a design that compared immediates with zero extension, or that mixed up the signed and unsigned orderings. Displacements include both extremes and negative values, so a design that zero-extended the offset or left out the +1 would land on the wrong target. Extra vectors wrap the counter at zero and at its maximum. The bench also checks that the unconditional jump and the return code in the 32-bit class are flagged illegal and never taken.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam logic [2:0] CLS_WIDE   = 3'd5;
  localparam logic [2:0] CLS_NARROW = 3'd6;

  typedef enum logic [3:0] {
    CND_ALWAYS = 4'h0, CND_EQ  = 4'h1, CND_UGT = 4'h2, CND_UGE = 4'h3,
    CND_TEST   = 4'h4, CND_NE  = 4'h5, CND_SGT = 4'h6, CND_SGE = 4'h7,
    CND_CALL   = 4'h8, CND_RET = 4'h9, CND_ULT = 4'ha, CND_ULE = 4'hb,
    CND_SLT    = 4'hc, CND_SLE = 4'hd, CND_RSVE = 4'he, CND_RSVF = 4'hf
  } cond_e;

  typedef struct packed {
    logic eq;
    logic ult;
    logic slt;
    logic any;
  } cmp_flags_t;
endpackage

// File: rtl/bcu_operand.sv
module bcu_operand #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 32
) (
  input  logic            use_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0] reg_val,
  output logic [XLEN-1:0] rhs
);
  localparam int EXT_W = XLEN - IMM_W;
  logic [XLEN-1:0] imm_ext;

  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign rhs     = use_reg ? reg_val : imm_ext;
endmodule

// File: rtl/bcu_compare.sv
module bcu_compare
  import bcu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cmp_flags_t   flags
);
  always_comb begin
    flags.eq  = (a == b);
    flags.ult = (a < b);
    flags.slt = ($signed(a) < $signed(b));
    flags.any = |(a & b);
  end
endmodule

// File: rtl/bcu_decide.sv
module bcu_decide
  import bcu_pkg::*;
(
  input  logic [2:0]  cls,
  input  logic [3:0]  cond,
  input  cmp_flags_t  f_wide,
  input  cmp_flags_t  f_narrow,
  output logic        taken,
  output logic        call,
  output logic        ret,
  output logic        illegal
);
  logic       is_wide, is_narrow;
  cmp_flags_t f;
  logic       hit, bad_code, want_call, want_ret;

  assign is_wide   = (cls == CLS_WIDE);
  assign is_narrow = (cls == CLS_NARROW);
  assign f         = is_narrow ? f_narrow : f_wide;

  always_comb begin
    hit       = 1'b0;
    bad_code  = 1'b0;
    want_call = 1'b0;
    want_ret  = 1'b0;
    unique case (cond_e'(cond))
      CND_ALWAYS: begin hit = 1'b1; bad_code = is_narrow; end
      CND_EQ:   hit = f.eq;
      CND_NE:   hit = !f.eq;
      CND_TEST: hit = f.any;
      CND_UGT:  hit = !f.ult && !f.eq;
      CND_UGE:  hit = !f.ult;
      CND_ULT:  hit = f.ult;
      CND_ULE:  hit = f.ult || f.eq;
      CND_SGT:  hit = !f.slt && !f.eq;
      CND_SGE:  hit = !f.slt;
      CND_SLT:  hit = f.slt;
      CND_SLE:  hit = f.slt || f.eq;
      CND_CALL: want_call = 1'b1;
      CND_RET:  begin want_ret = 1'b1; bad_code = is_narrow; end
      default:  bad_code = 1'b1;
    endcase
  end

  assign illegal = !(is_wide || is_narrow) || bad_code;
  assign taken   = !illegal && hit;
  assign call    = !illegal && want_call;
  assign ret     = !illegal && want_ret;
endmodule

// File: rtl/bcu_target.sv
module bcu_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic             taken,
  output logic [PC_W-1:0]  next_pc
);
  localparam int EXT_W = PC_W - OFF_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(1);
  logic [PC_W-1:0] disp;

  assign disp    = taken ? {{EXT_W{off[OFF_W-1]}}, off} : '0;
  assign next_pc = pc + STEP + disp;
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import bcu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int IMM_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       opcode_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0]  dst_val_i,
  input  logic [XLEN-1:0]  src_val_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             call_o,
  output logic             exit_o,
  output logic             illegal_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] rhs;
  cmp_flags_t      lane_flags [2];
  logic            taken_d, call_d, ret_d, illegal_d;
  logic [PC_W-1:0] next_d;
  logic            live_q;

  bcu_operand #(.XLEN(XLEN), .IMM_W(IMM_W)) u_operand (
    .use_reg (opcode_i[3]),
    .imm     (imm_i),
    .reg_val (src_val_i),
    .rhs     (rhs)
  );

  // lane 0 compares full width, lane 1 the low half
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LW = (g == 0) ? XLEN : HALF;
    bcu_compare #(.W(LW)) u_cmp (
      .a     (dst_val_i[LW-1:0]),
      .b     (rhs[LW-1:0]),
      .flags (lane_flags[g])
    );
  end

  bcu_decide u_decide (
    .cls      (opcode_i[2:0]),
    .cond     (opcode_i[7:4]),
    .f_wide   (lane_flags[0]),
    .f_narrow (lane_flags[1]),
    .taken    (taken_d),
    .call     (call_d),
    .ret      (ret_d),
    .illegal  (illegal_d)
  );

  bcu_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
    .pc      (pc_i),
    .off     (offset_i),
    .taken   (taken_d),
    .next_pc (next_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o   <= 1'b0;
      next_pc_o <= '0;
      call_o    <= 1'b0;
      exit_o    <= 1'b0;
      illegal_o <= 1'b0;
      live_q    <= 1'b0;
    end else begin
      taken_o   <= taken_d;
      next_pc_o <= next_d;
      call_o    <= call_d;
      exit_o    <= ret_d;
      illegal_o <= illegal_d;
      live_q    <= 1'b1;
    end
  end

  // ---------------- assertions ----------------
  localparam logic [PC_W-1:0] ONE_PC = PC_W'(1);

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({taken_o, call_o, exit_o, illegal_o}));

  assert_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
    (live_q && !taken_o) |-> (next_pc_o == $past(pc_i) + ONE_PC));

  assert_target_R7: assert property (@(posedge clk) disable iff (rst)
    (live_q && taken_o) |-> (next_pc_o == $past(pc_i) + ONE_PC
      + {{(PC_W-OFF_W){$past(offset_i[OFF_W-1])}}, $past(offset_i)}));

  assert_exit_class_R9: assert property (@(posedge clk) disable iff (rst)
    (live_q && exit_o) |-> ($past(opcode_i) == {CND_RET, 1'b0, CLS_WIDE}
                         || $past(opcode_i) == {CND_RET, 1'b1, CLS_WIDE}));

  assert_narrow_always_R8: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(opcode_i[2:0]) == CLS_NARROW && $past(opcode_i[7:4]) == 4'h0)
      |-> illegal_o);

  assert_class_illegal_R2: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(opcode_i[2:0]) != CLS_WIDE && $past(opcode_i[2:0]) != CLS_NARROW)
      |-> (illegal_o && !taken_o));
endmodule

// File: tb/tb_branch_unit.sv
module tb_branch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  opcode_i = '0;
  logic [15:0] offset_i = '0;
  logic [31:0] imm_i = '0;
  logic [63:0] dst_val_i = '0;
  logic [63:0] src_val_i = '0;
  logic [31:0] pc_i = '0;
  logic        taken_o, call_o, exit_o, illegal_o;
  logic [31:0] next_pc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  branch_unit dut (
    .clk(clk), .rst(rst), .opcode_i(opcode_i), .offset_i(offset_i),
    .imm_i(imm_i), .dst_val_i(dst_val_i), .src_val_i(src_val_i), .pc_i(pc_i),
    .taken_o(taken_o), .next_pc_o(next_pc_o), .call_o(call_o),
    .exit_o(exit_o), .illegal_o(illegal_o)
  );

  // expected = {taken, call, exit, illegal, next_pc}
  function automatic logic [35:0] model(input logic [7:0] op, input logic [15:0] off,
      input logic [31:0] imm, input logic [63:0] a, input logic [63:0] r, input logic [31:0] pc);
    logic [63:0] b;
    logic [3:0]  c;
    logic        narrow, wide, t, cl, ex, il;
    logic        eq, lt_u, lt_s, nz;
    c = op[7:4];
    wide = (op[2:0] == 3'd5);
    narrow = (op[2:0] == 3'd6);
    b = op[3] ? r : {{32{imm[31]}}, imm};  // R3
    if (narrow) begin
      eq = a[31:0] == b[31:0];
      lt_u = a[31:0] < b[31:0];
      lt_s = $signed(a[31:0]) < $signed(b[31:0]);
      nz = (a[31:0] & b[31:0]) != 0;
    end else begin
      eq = a == b;
      lt_u = a < b;
      lt_s = $signed(a) < $signed(b);
      nz = (a & b) != 0;
    end
    t = 0; cl = 0; ex = 0;
    il = !(wide || narrow) || c == 4'he || c == 4'hf
         || (narrow && (c == 4'h0 || c == 4'h9));
    if (!il) begin
      case (c)
        4'h0: t = 1;
        4'h1: t = eq;
        4'h5: t = !eq;
        4'h4: t = nz;
        4'h2: t = !lt_u && !eq;
        4'h3: t = !lt_u;
        4'ha: t = lt_u;
        4'hb: t = lt_u || eq;
        4'h6: t = !lt_s && !eq;
        4'h7: t = !lt_s;
        4'hc: t = lt_s;
        4'hd: t = lt_s || eq;
        4'h8: cl = 1;
        4'h9: ex = 1;
        default: ;
      endcase
    end
    return {t, cl, ex, il, pc + 32'd1 + (t ? {{16{off[15]}}, off} : 32'd0)};
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    logic [3:0] c;
    c = op[7:4];
    if (op[2:0] != 3'd5 && op[2:0] != 3'd6) return "R2";
    if (c == 4'he || c == 4'hf) return "R10";
    if (c == 4'h0) return "R8";
    if (c == 4'h8 || c == 4'h9) return "R9";
    if (c == 4'h1 || c == 4'h4 || c == 4'h5) return "R4";
    if (c == 4'h6 || c == 4'h7 || c == 4'hc || c == 4'hd) return "R6";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic [35:0] exp);
    logic [35:0] got;
    got = {taken_o, call_o, exit_o, illegal_o, next_pc_o};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%02h actual t/c/e/i=%b next=%08h expected t/c/e/i=%b next=%08h",
               tag, opcode_i, got[35:32], got[31:0], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [15:0] off, input logic [31:0] imm,
                       input logic [63:0] a, input logic [63:0] r, input logic [31:0] pc,
                       input string tag);
    @(negedge clk);
    opcode_i = op; offset_i = off; imm_i = imm;
    dst_val_i = a; src_val_i = r; pc_i = pc;
    @(negedge clk);
    check({tag, " (operand R3, target R7)"}, model(op, off, imm, a, r, pc));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  logic [63:0] va [8];
  logic [63:0] vr [8];
  logic [31:0] vi [8];
  logic [15:0] vo [8];

  initial begin
    va[0] = 64'd5;                   vr[0] = 64'd5;                   vi[0] = 32'd5;          vo[0] = 16'h0010;
    va[1] = 64'h0000_0001_0000_0005; vr[1] = 64'd5;                   vi[1] = 32'd5;          vo[1] = 16'hFFF0;
    va[2] = 64'hFFFF_FFFF_FFFF_FFFF; vr[2] = 64'd1;                   vi[2] = 32'd1;          vo[2] = 16'h7FFF;
    va[3] = 64'h0000_0000_8000_0000; vr[3] = 64'd1;                   vi[3] = 32'h7FFF_FFFF;  vo[3] = 16'h8000;
    va[4] = 64'd3;                   vr[4] = 64'hFFFF_FFFF_FFFF_FFFE; vi[4] = 32'hFFFF_FFFE;  vo[4] = 16'h0001;
    va[5] = 64'h0000_0000_0000_00F0; vr[5] = 64'h0F;                  vi[5] = 32'h0F;         vo[5] = 16'hFFFF;
    va[6] = 64'h0000_0001_0000_0000; vr[6] = 64'h0000_0001_0000_0000; vi[6] = 32'd0;          vo[6] = 16'h0100;
    va[7] = 64'd0;                   vr[7] = 64'h8000_0000_0000_0000; vi[7] = 32'h8000_0000;  vo[7] = 16'hFF00;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", 36'd0);
    rst = 1'b0;

    for (int op = 0; op < 256; op++) begin
      for (int v = 0; v < 8; v++) begin
        apply(8'(op), vo[v], vi[v], va[v], vr[v], 32'h0000_1000 + 32'(v * 64), tag_of(8'(op)));
      end
    end

    // R7: counter wrap cases
    apply(8'h05, 16'h0000, 32'd0, 64'd0, 64'd0, 32'hFFFF_FFFF, "R7 wrap up");
    apply(8'h05, 16'hFFFF, 32'd0, 64'd0, 64'd0, 32'h0000_0000, "R7 back to self");
    apply(8'h05, 16'hFFFD, 32'd0, 64'd0, 64'd0, 32'h0000_0001, "R7 wrap down");
    apply(8'h15, 16'h0004, 32'd0, 64'd1, 64'd0, 32'hFFFF_FFFF, "R7 fallthrough wrap");

    // R11: outputs hold until the next rising edge
    apply(8'h05, 16'h0020, 32'd0, 64'd0, 64'd0, 32'h0000_0100, "R11 setup");
    @(negedge clk);
    opcode_i = 8'hF0; pc_i = 32'h0000_0500;
    #2;
    check("R11 before edge", model(8'h05, 16'h0020, 32'd0, 64'd0, 64'd0, 32'h0000_0100));
    @(negedge clk);
    check("R11 after edge", model(8'hF0, 16'h0020, 32'd0, 64'd0, 64'd0, 32'h0000_0500));

    // R1: reset clears outputs after activity
    @(negedge clk);
    opcode_i = 8'h05; rst = 1'b1;
    @(negedge clk);
    check("R1 re-reset", 36'd0);
    rst = 1'b0;

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule